// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller

This block is the register-facing control logic for a 64-input multiplexed analog-to-digital converter. Software programs a scan window (first and last channel), picks what starts a conversion (a write strobe, either edge of an external trigger line, or a tick from an outside pacer counter), and picks which FIFO event raises the interrupt. Each accepted trigger converts the channel under the scan pointer. The pointer then moves one channel up, and after the last channel of the window it goes back to the first.

Results queue in a sample FIFO that software drains through the data address. A status word reports the fill level and the pending flags. A behavioural converter model sits inside the block. It returns a value that depends on the channel after a fixed number of cycles, so the control path can be exercised on its own. The register map uses five word addresses: 0 data, 1 scan window, 2 status, 3 control, 4 mode.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the status word reads 0, control reads 0, scan window reads 0, mode reads 0x0060 (single-ended, unipolar, no interrupt source), irq is low, and a data read returns 0.
- R2: The scan window word holds the first channel in bits 5:0 and the last channel in bits 13:8, and it reads back as written with the other bits zero. Writing it sends the scan pointer back to the first channel.
- R3: Each accepted trigger converts the channel under the pointer and then advances the pointer. After the last channel the pointer returns to the first, so equal limits repeat one channel.
- R4: Control bits 1:0 choose the trigger: 0 is any write to address 0, 1 is a falling edge of ext_trig, 2 is a rising edge of ext_trig, 3 is a pacer_tick pulse. The sources not chosen start nothing.
- R5: A channel c converts to the value v = (c*37+5) mod 2^RES_BITS. The stored data word is v shifted left by 16-RES_BITS, with the bits below it zero.
- R6: A read of address 0 returns the oldest sample and removes it. A read of address 0 while the FIFO is empty returns 0.
- R7: Status bit 0 is FIFO not empty, bit 1 is at least half full, bit 2 is full. A sample that arrives while the FIFO is full is dropped, the pointer still advances, and the full flag stays set until a read.
- R8: Mode bits 3:2 choose the interrupt event: 0 none, 1 any stored sample, 2 the FIFO reaching half full, 3 a stored sample from the last window channel. The event sets status bit 4, and irq equals that bit ANDed with control bit 7.
- R9: Writing status with bit 0 set clears bit 4. An accepted external-edge trigger sets status bit 5, and writing status with bit 1 set clears it.
- R10: With mode bit 5 at 0 (differential), a trigger on a channel above 32 stores no sample but still advances the pointer.
- R11: A trigger that arrives while a conversion is in progress is ignored and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at address 0) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ext_trig | input | 1 | External trigger line |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the wrap point of the scan: a window whose last channel is 63 and a window of a single channel. If the design ran the pointer past the last channel, the sample order would be wrong. It overfills the FIFO and then checks that the next sample carries the pointer position reached after the dropped triggers. A design that stalled or rewound on a drop would store the wrong channel. It also fires a second trigger during a running conversion and checks that the following sample uses the next channel, so a design that queued or counted the ignored trigger would skip a channel. Each interrupt source and the channel limit in differential mode are checked where a single off-by-one would shift the flag or store an extra sample.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CHAN_W    = 6;
    localparam int DIFF_LAST = 32;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_SCAN = 3'd1,
        A_STAT = 3'd2,
        A_CTRL = 3'd3,
        A_MODE = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRG_SW    = 2'd0,
        TRG_FALL  = 2'd1,
        TRG_RISE  = 2'd2,
        TRG_PACER = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        IEV_NONE  = 2'd0,
        IEV_ANY   = 2'd1,
        IEV_HALF  = 2'd2,
        IEV_BURST = 2'd3
    } irq_sel_e;

    typedef struct packed {
        logic [CHAN_W-1:0] last;
        logic [CHAN_W-1:0] first;
    } scan_win_t;

    typedef struct packed {
        logic     unipolar;
        logic     single_end;
        irq_sel_e irq_sel;
    } mode_t;

    typedef struct packed {
        logic      irq_en;
        trig_src_e src;
    } ctrl_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [15:0]       word;
    } sample_t;

    function automatic logic [15:0] conv_word(input logic [CHAN_W-1:0] ch, input int res);
        logic [31:0] raw;
        logic [31:0] mask;
        raw  = 32'(ch) * 32'd37 + 32'd5;
        mask = (32'h1 << res) - 32'h1;
        raw  = (raw & mask) << (16 - res);
        return raw[15:0];
    endfunction

endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
    import adc_scan_pkg::*;
#(
    parameter int LAT      = 4,
    parameter int RES_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CHAN_W-1:0] chan,
    output logic              busy,
    output logic              done,
    output sample_t           result
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]     cnt;
    logic [CHAN_W-1:0] chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            chan_q <= '0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                cnt    <= CW'(LAT);
                chan_q <= chan;
            end else if (busy) begin
                if (cnt == CW'(1)) begin
                    busy        <= 1'b0;
                    done        <= 1'b1;
                    result.chan <= chan_q;
                    result.word <= conv_word(chan_q, RES_BITS);
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CNW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNW'(1);
                2'b01:   count <= count - CNW'(1);
                default: count <= count;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CNW'(DEPTH)));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNW'(DEPTH));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  scan_win_t         win,
    input  logic              win_load,
    input  logic [CHAN_W-1:0] load_first,
    input  trig_src_e         src,
    input  logic              single_end,
    input  logic              sw_hit,
    input  logic              ext_trig,
    input  logic              pacer_tick,
    input  logic              conv_busy,
    output logic              start,
    output logic [CHAN_W-1:0] start_chan,
    output logic              ext_hit
);
    logic              ext_s1;
    logic              ext_s2;
    logic              rise;
    logic              fall;
    logic              trig;
    logic              fire;
    logic [CHAN_W-1:0] ptr;

    assign rise = ext_s1 && !ext_s2;
    assign fall = !ext_s1 && ext_s2;

    always_comb begin
        case (src)
            TRG_SW:    trig = sw_hit;
            TRG_FALL:  trig = fall;
            TRG_RISE:  trig = rise;
            default:   trig = pacer_tick;
        endcase
    end

    assign fire       = trig && !conv_busy;
    assign start      = fire && (single_end || (ptr <= CHAN_W'(DIFF_LAST)));
    assign start_chan = ptr;
    assign ext_hit    = fire && ((src == TRG_FALL) || (src == TRG_RISE));

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_s1 <= 1'b0;
            ext_s2 <= 1'b0;
            ptr    <= '0;
        end else begin
            ext_s1 <= ext_trig;
            ext_s2 <= ext_s1;
            if (win_load)
                ptr <= load_first;
            else if (fire)
                ptr <= (ptr == win.last) ? win.first : ptr + CHAN_W'(1);
        end
    end

    a_r3_wrap_to_first: assert property (@(posedge clk) disable iff (rst)
        ($past(fire) && !$past(win_load) && ($past(ptr) == $past(win.last)))
        |-> (ptr == $past(win.first)));

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int FIFO_DEPTH = 16,
    parameter int CONV_LAT   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        ext_trig,
    input  logic        pacer_tick,
    output logic        irq
);
    localparam int CNW  = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = FIFO_DEPTH / 2;

    scan_win_t         win_q;
    ctrl_t             ctrl_q;
    mode_t             mode_q;
    logic              pending;
    logic              ext_flag;

    logic              wr_data, wr_scan, wr_stat, wr_ctrl, wr_mode, rd_data;
    logic              start, conv_busy, conv_done, ext_hit;
    logic [CHAN_W-1:0] start_chan;
    sample_t           conv_res;
    logic [15:0]       head;
    logic [CNW-1:0]    count;
    logic              empty, full, half;
    logic              irq_event;
    logic              unused_bits;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_scan = bus_wr && (bus_addr == A_SCAN);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign rd_data = bus_rd && (bus_addr == A_DATA);
    assign half    = (count >= CNW'(HALF));

    assign unused_bits = ^{bus_wdata[15:14], bus_wdata[7:6], bus_wdata[4], bus_wdata[1:0]};

    adc_scan_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .win        (win_q),
        .win_load   (wr_scan),
        .load_first (bus_wdata[5:0]),
        .src        (ctrl_q.src),
        .single_end (mode_q.single_end),
        .sw_hit     (wr_data),
        .ext_trig   (ext_trig),
        .pacer_tick (pacer_tick),
        .conv_busy  (conv_busy),
        .start      (start),
        .start_chan (start_chan),
        .ext_hit    (ext_hit)
    );

    adc_conv_stub #(.LAT(CONV_LAT), .RES_BITS(RES_BITS)) u_conv (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .chan   (start_chan),
        .busy   (conv_busy),
        .done   (conv_done),
        .result (conv_res)
    );

    adc_sample_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(16)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (conv_done),
        .din   (conv_res.word),
        .pop   (rd_data),
        .dout  (head),
        .count (count),
        .empty (empty),
        .full  (full)
    );

    always_comb begin
        irq_event = 1'b0;
        if (conv_done && !full) begin
            case (mode_q.irq_sel)
                IEV_ANY:   irq_event = 1'b1;
                IEV_HALF:  irq_event = ((count + CNW'(1)) >= CNW'(HALF));
                IEV_BURST: irq_event = (conv_res.chan == win_q.last);
                default:   irq_event = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            ctrl_q   <= '0;
            mode_q   <= '{unipolar: 1'b1, single_end: 1'b1, irq_sel: IEV_NONE};
            pending  <= 1'b0;
            ext_flag <= 1'b0;
        end else begin
            if (wr_scan) begin
                win_q.first <= bus_wdata[5:0];
                win_q.last  <= bus_wdata[13:8];
            end
            if (wr_ctrl) begin
                ctrl_q.src    <= trig_src_e'(bus_wdata[1:0]);
                ctrl_q.irq_en <= bus_wdata[7];
            end
            if (wr_mode) begin
                mode_q.irq_sel    <= irq_sel_e'(bus_wdata[3:2]);
                mode_q.single_end <= bus_wdata[5];
                mode_q.unipolar   <= bus_wdata[6];
            end
            if (irq_event)
                pending <= 1'b1;
            else if (wr_stat && bus_wdata[0])
                pending <= 1'b0;
            if (ext_hit)
                ext_flag <= 1'b1;
            else if (wr_stat && bus_wdata[1])
                ext_flag <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = empty ? 16'h0000 : head;
            A_SCAN:  bus_rdata = {2'b00, win_q.last, 2'b00, win_q.first};
            A_STAT:  bus_rdata = {10'd0, ext_flag, pending, 1'b0, full, half, !empty};
            A_CTRL:  bus_rdata = {8'd0, ctrl_q.irq_en, 5'd0, ctrl_q.src};
            A_MODE:  bus_rdata = {9'd0, mode_q.unipolar, mode_q.single_end, 1'b0,
                                  mode_q.irq_sel, 2'b00};
            default: bus_rdata = 16'h0000;
        endcase
    end

    assign irq = pending && ctrl_q.irq_en;

    a_r9_clear_pending: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[0] && !irq_event) |=> !pending);

    a_r11_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !conv_busy);

    a_r10_diff_range: assert property (@(posedge clk) disable iff (rst)
        (start && !mode_q.single_end) |-> (start_chan <= CHAN_W'(DIFF_LAST)));

    a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(conv_done));

endmodule

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
    localparam int LAT   = 4;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        pacer_tick = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    adc_scan_ctrl #(.RES_BITS(12), .FIFO_DEPTH(DEPTH), .CONV_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .pacer_tick(pacer_tick), .irq(irq)
    );

    // first, last, trigger count
    localparam logic [17:0] SCANS [0:3] = '{
        {6'd5,  6'd8,  6'd6},
        {6'd10, 6'd10, 6'd3},
        {6'd62, 6'd63, 6'd3},
        {6'd0,  6'd2,  6'd7}
    };

    function automatic logic [15:0] exp_word(input int ch);
        int v;
        v = (ch * 37 + 5) % 4096;
        return 16'(v << 4);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (LAT + 4) @(posedge clk);
    endtask

    task automatic sw_conv();
        wr(3'd0, 16'h0);
        settle();
    endtask

    task automatic pulse_pacer();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
        settle();
    endtask

    task automatic drain();
        logic [15:0] s;
        for (int i = 0; i < DEPTH + 2; i++) begin
            rd(3'd2, s);
            if (s[0]) rd(3'd0, s);
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int ch;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd2, v); chk("R1 status", v, 16'h0000);
        rd(3'd3, v); chk("R1 ctrl", v, 16'h0000);
        rd(3'd1, v); chk("R1 scan", v, 16'h0000);
        rd(3'd4, v); chk("R1 mode", v, 16'h0060);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        rd(3'd0, v); chk("R1 R6 empty data read", v, 16'h0000);

        // R3 R5 table of scan windows
        for (int i = 0; i < 4; i++) begin
            int lo, hi, n;
            lo = int'(SCANS[i][17:12]);
            hi = int'(SCANS[i][11:6]);
            n  = int'(SCANS[i][5:0]);
            wr(3'd1, 16'((hi << 8) | lo));
            for (int k = 0; k < n; k++) sw_conv();
            ch = lo;
            for (int k = 0; k < n; k++) begin
                rd(3'd0, v);
                chk("R3 R5 scan sample", v, exp_word(ch));
                ch = (ch == hi) ? lo : ch + 1;
            end
            rd(3'd2, v); chk("R6 emptied", v, 16'h0000);
        end

        // R2 readback and pointer reload
        wr(3'd1, 16'h0603);
        rd(3'd1, v); chk("R2 readback", v, 16'h0603);
        wr(3'd1, 16'hFFC3);
        rd(3'd1, v); chk("R2 unused bits zero", v, 16'h3F03);
        wr(3'd1, 16'h0603);
        sw_conv(); sw_conv();
        wr(3'd1, 16'h0603);
        sw_conv();
        rd(3'd0, v); chk("R2 first", v, exp_word(3));
        rd(3'd0, v); chk("R2 second", v, exp_word(4));
        rd(3'd0, v); chk("R2 reload to first", v, exp_word(3));

        // R4 trigger source selection, single channel 7
        wr(3'd1, 16'h0707);
        pulse_pacer();
        rd(3'd2, v); chk("R4 pacer ignored in sw mode", v, 16'h0000);
        wr(3'd3, 16'h0003);
        sw_conv();
        rd(3'd2, v); chk("R4 write ignored in pacer mode", v, 16'h0000);
        pulse_pacer();
        rd(3'd0, v); chk("R4 pacer sample", v, exp_word(7));
        wr(3'd3, 16'h0002);
        @(negedge clk) ext_trig = 1'b1; settle();
        rd(3'd0, v); chk("R4 rising edge sample", v, exp_word(7));
        rd(3'd2, v); chk("R9 ext flag set", v, 16'h0020);
        @(negedge clk) ext_trig = 1'b0; settle();
        rd(3'd2, v); chk("R4 falling ignored in rising mode", v, 16'h0020);
        wr(3'd2, 16'h0002);
        rd(3'd2, v); chk("R9 ext flag cleared", v, 16'h0000);
        wr(3'd3, 16'h0001);
        @(negedge clk) ext_trig = 1'b1; settle();
        rd(3'd2, v); chk("R4 rising ignored in falling mode", v, 16'h0000);
        @(negedge clk) ext_trig = 1'b0; settle();
        rd(3'd0, v); chk("R4 falling edge sample", v, exp_word(7));
        wr(3'd2, 16'h0002);
        wr(3'd3, 16'h0000);

        // R7 fill levels and drop on full
        wr(3'd1, 16'h3F00);
        for (int k = 0; k < 7; k++) sw_conv();
        rd(3'd2, v); chk("R7 below half", v, 16'h0001);
        sw_conv();
        rd(3'd2, v); chk("R7 half", v, 16'h0003);
        for (int k = 0; k < 8; k++) sw_conv();
        rd(3'd2, v); chk("R7 full", v, 16'h0007);
        sw_conv(); sw_conv();
        rd(3'd2, v); chk("R7 full stays", v, 16'h0007);
        rd(3'd0, v); chk("R7 oldest", v, exp_word(0));
        rd(3'd2, v); chk("R7 space after read", v, 16'h0003);
        sw_conv();
        for (int k = 1; k < 16; k++) begin
            rd(3'd0, v); chk("R7 kept order", v, exp_word(k));
        end
        rd(3'd0, v); chk("R7 pointer moved past drops", v, exp_word(18));

        // R8 R9 interrupt sources
        wr(3'd1, 16'h0909);
        wr(3'd4, 16'h0064);
        wr(3'd3, 16'h0080);
        sw_conv();
        rd(3'd2, v); chk("R8 any-sample pending", v, 16'h0011);
        chk("R8 irq high", {15'd0, irq}, 16'h0001);
        wr(3'd2, 16'h0001);
        rd(3'd2, v); chk("R9 pending cleared", v, 16'h0001);
        chk("R9 irq low", {15'd0, irq}, 16'h0000);
        wr(3'd3, 16'h0000);
        sw_conv();
        rd(3'd2, v); chk("R8 pending with irq disabled", v, 16'h0011);
        chk("R8 irq masked", {15'd0, irq}, 16'h0000);
        wr(3'd2, 16'h0001);
        drain();

        wr(3'd4, 16'h006C);
        wr(3'd1, 16'h0402);
        sw_conv(); sw_conv();
        rd(3'd2, v); chk("R8 burst not yet", v, 16'h0001);
        sw_conv();
        rd(3'd2, v); chk("R8 burst at last channel", v, 16'h0011);
        wr(3'd2, 16'h0001);
        drain();

        wr(3'd4, 16'h0068);
        for (int k = 0; k < 7; k++) sw_conv();
        rd(3'd2, v); chk("R8 half not yet", v, 16'h0001);
        sw_conv();
        rd(3'd2, v); chk("R8 half reached", v, 16'h0013);
        wr(3'd2, 16'h0001);
        drain();

        // R10 differential channel limit
        wr(3'd4, 16'h0000);
        wr(3'd1, 16'h2220);
        for (int k = 0; k < 4; k++) sw_conv();
        rd(3'd0, v); chk("R10 ch32 converts", v, exp_word(32));
        rd(3'd0, v); chk("R10 ch33 34 skipped", v, exp_word(32));
        rd(3'd2, v); chk("R10 nothing more", v, 16'h0000);
        wr(3'd4, 16'h0060);

        // R11 trigger during conversion
        wr(3'd1, 16'h1514);
        wr(3'd0, 16'h0);
        wr(3'd0, 16'h0);
        settle();
        rd(3'd2, v); chk("R11 one sample", v, 16'h0001);
        sw_conv();
        rd(3'd0, v); chk("R11 first", v, exp_word(20));
        rd(3'd0, v); chk("R11 next channel not skipped", v, exp_word(21));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule